// File: doc/BRIEF.md
# Dual Zero-Overhead Loop Controller

This block lets a processor repeat a body of code without spending any instruction on the loop branch. It holds two loop register sets, loop 0 and loop 1. Each set has a first-instruction address, a last-instruction address and a remaining-iteration count. Software loads these values through a small register write port. The fetch unit presents each program counter together with a valid strobe.

When a valid program counter equals the last-instruction address of a loop whose count is above one, the block raises a jump request in the same cycle and supplies that loop's first address as the target. It also decrements the count on the clock edge. When both loops close on the same address, loop 0 is served first. On loop 0's last pass the request hands over to loop 1: both counts step down and fetch goes to loop 1's first address. Because the redirect is combinational, a body as short as two instructions can be repeated with no bubble. All six values can be read back at any time.

Top module: `zol_ctrl`

## Requirements
- R1: After reset all six read-back values are zero and `jump_o` is low.
- R2: A write with `csr_we_i` high lands at an address made from the base 0x7B0 as follows. Bit 2 picks the loop (0 for loop 0, 1 for loop 1). Bits 1:0 pick the field: 0 is the first address, 1 is the last address, 2 is the count. The written value shows on the matching read-back output after the next rising clock edge.
- R3: The write port leaves all six values unchanged in two cases. The first is `csr_we_i` low, whatever the address. The second is an address outside the six decoded ones: field code 3 (0x7B3, 0x7B7), or any address outside 0x7B0..0x7B7.
- R4: Suppose `pc_valid_i` is high, `pc_i` equals one loop's last address, that loop's count is greater than 1, and no higher-priority loop claims the cycle. Then `jump_o` is high in that same cycle, `jump_target_o` equals that loop's first address, and the count drops by one at the next edge.
- R5: A loop whose count is 0 or 1 when the valid PC equals its last address does not cause a jump. Its count is 0 after the edge.
- R6: While `pc_valid_i` is low, `jump_o` stays low and neither count changes.
- R7: Suppose both loops share the last address, the valid PC hits it, and loop 0's count is greater than 1. Then the target is loop 0's first address, loop 0's count decrements, and loop 1's count is unchanged.
- R8: Suppose both loops share the last address, the valid PC hits it, loop 0's count is 0 or 1, and loop 1's count is greater than 1. Then the target is loop 1's first address, loop 0's count becomes 0, and loop 1's count decrements.
- R9: A count write to a loop may fall in the same cycle as a decrement of that loop. The written value is then stored and the decrement is dropped. The jump decision for that cycle still uses the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Program counter of the fetch stage |
| pc_valid_i | input | 1 | `pc_i` holds a real instruction address |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 12 | Register write address |
| csr_wdata_i | input | 32 | Register write data |
| jump_o | output | 1 | Redirect fetch this cycle |
| jump_target_o | output | 32 | Redirect address, valid while `jump_o` is high |
| loop0_start_o | output | 32 | Loop 0 first address |
| loop0_end_o | output | 32 | Loop 0 last address |
| loop0_count_o | output | 32 | Loop 0 remaining count |
| loop1_start_o | output | 32 | Loop 1 first address |
| loop1_end_o | output | 32 | Loop 1 last address |
| loop1_count_o | output | 32 | Loop 1 remaining count |

## Verification
A stepped table drives separate end addresses for the two loops. Within it, PCs inside the body are told apart from PCs on the last address. A valid strobe is contrasted with a dropped one, and counts of 3, 2, 1 and 0 at the end are contrasted, which separates the jump, fall-through and saturation cases for each loop. A second pattern places both loops on one last address and walks the counts down through the priority case, the hand-over case and the case with loop 0 exhausted. This shows whether priority and double decrement follow loop 0's count. Separate patterns write undecoded addresses and hold the strobe low, and one collides a count write with a decrement.

// File: rtl/zol_pkg.sv
package zol_pkg;

    parameter int unsigned ZOL_XLEN   = 32;
    parameter int unsigned ZOL_ADDR_W = 32;
    parameter int unsigned ZOL_CNT_W  = 32;
    parameter int unsigned ZOL_NLOOPS = 2;
    parameter int unsigned ZOL_CSR_W  = 12;

    // bit that selects the loop inside the register window
    localparam int unsigned ZOL_SEL_BIT = 2;

    typedef logic [ZOL_ADDR_W-1:0] addr_t;
    typedef logic [ZOL_CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        FLD_START = 2'd0,
        FLD_END   = 2'd1,
        FLD_COUNT = 2'd2,
        FLD_NONE  = 2'd3
    } fld_e;

    typedef struct packed {
        addr_t start_addr;
        addr_t end_addr;
        cnt_t  count;
    } loop_regs_t;

    typedef struct packed {
        logic start_we;
        logic end_we;
        logic count_we;
    } loop_wr_t;

    function automatic cnt_t cnt_step_down(input cnt_t c);
        return (c == '0) ? '0 : c - cnt_t'(1);
    endfunction

endpackage

// File: rtl/zol_csr_dec.sv
module zol_csr_dec
    import zol_pkg::*;
#(
    parameter logic [ZOL_CSR_W-1:0] CSR_BASE = 12'h7B0
) (
    input  logic                 csr_we_i,
    input  logic [ZOL_CSR_W-1:0] csr_addr_i,
    output loop_wr_t             wr_o [ZOL_NLOOPS]
);

    logic in_window;
    logic sel;
    fld_e fld;

    assign in_window = (csr_addr_i[ZOL_CSR_W-1:ZOL_SEL_BIT+1]
                        == CSR_BASE[ZOL_CSR_W-1:ZOL_SEL_BIT+1]);
    assign sel       = csr_addr_i[ZOL_SEL_BIT];
    assign fld       = fld_e'(csr_addr_i[1:0]);

    for (genvar g = 0; g < ZOL_NLOOPS; g++) begin : g_loop_wr
        localparam logic MY_SEL = 1'(g);
        logic hit;
        assign hit = csr_we_i && in_window && (sel == MY_SEL);
        always_comb begin
            wr_o[g].start_we = hit && (fld == FLD_START);
            wr_o[g].end_we   = hit && (fld == FLD_END);
            wr_o[g].count_we = hit && (fld == FLD_COUNT);
        end
    end

endmodule

// File: rtl/zol_regset.sv
module zol_regset
    import zol_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  loop_wr_t            wr_i,
    input  logic [ZOL_XLEN-1:0] wdata_i,
    input  logic                step_i,
    output loop_regs_t          regs_o
);

    loop_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i.start_we) begin
            regs_d.start_addr = wdata_i[ZOL_ADDR_W-1:0];
        end
        if (wr_i.end_we) begin
            regs_d.end_addr = wdata_i[ZOL_ADDR_W-1:0];
        end
        // a software load of the count beats the hardware step
        if (wr_i.count_we) begin
            regs_d.count = wdata_i[ZOL_CNT_W-1:0];
        end else if (step_i) begin
            regs_d.count = cnt_step_down(regs_q.count);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    AST_COUNT_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i.count_we |=> regs_q.count == $past(wdata_i[ZOL_CNT_W-1:0])); // R9

    AST_COUNT_STEPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !wr_i.count_we && regs_q.count != '0)
        |=> regs_q.count == $past(regs_q.count) - cnt_t'(1)); // R4

    AST_COUNT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !wr_i.count_we) |=> $stable(regs_q.count)); // R6

endmodule

// File: rtl/zol_arbiter.sv
module zol_arbiter
    import zol_pkg::*;
(
    input  addr_t      pc_i,
    input  logic       pc_valid_i,
    input  loop_regs_t regs_i [ZOL_NLOOPS],
    output logic       step_o [ZOL_NLOOPS],
    output logic       jump_o,
    output addr_t      jump_target_o
);

    logic hit0, hit1;
    logic more0, more1;
    logic take0, take1;

    always_comb begin
        hit0  = pc_valid_i && (pc_i == regs_i[0].end_addr);
        hit1  = pc_valid_i && (pc_i == regs_i[1].end_addr);
        more0 = regs_i[0].count > cnt_t'(1);
        more1 = regs_i[1].count > cnt_t'(1);

        // loop 0 has first claim on a shared end address
        take0 = hit0 && more0;
        // loop 1 steps unless loop 0 is still iterating on this address
        step_o[0] = hit0;
        step_o[1] = hit1 && !take0;
        take1     = step_o[1] && more1;

        jump_o = take0 || take1;
        if (take0) begin
            jump_target_o = regs_i[0].start_addr;
        end else if (take1) begin
            jump_target_o = regs_i[1].start_addr;
        end else begin
            jump_target_o = '0;
        end
    end

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
    import zol_pkg::*;
#(
    parameter logic [ZOL_CSR_W-1:0] CSR_BASE = 12'h7B0
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [ZOL_ADDR_W-1:0] pc_i,
    input  logic                  pc_valid_i,
    input  logic                  csr_we_i,
    input  logic [ZOL_CSR_W-1:0]  csr_addr_i,
    input  logic [ZOL_XLEN-1:0]   csr_wdata_i,
    output logic                  jump_o,
    output logic [ZOL_ADDR_W-1:0] jump_target_o,
    output logic [ZOL_ADDR_W-1:0] loop0_start_o,
    output logic [ZOL_ADDR_W-1:0] loop0_end_o,
    output logic [ZOL_CNT_W-1:0]  loop0_count_o,
    output logic [ZOL_ADDR_W-1:0] loop1_start_o,
    output logic [ZOL_ADDR_W-1:0] loop1_end_o,
    output logic [ZOL_CNT_W-1:0]  loop1_count_o
);

    loop_wr_t   wr_s   [ZOL_NLOOPS];
    loop_regs_t regs_s [ZOL_NLOOPS];
    logic       step_s [ZOL_NLOOPS];

    zol_csr_dec #(
        .CSR_BASE (CSR_BASE)
    ) csr_dec_i (
        .csr_we_i   (csr_we_i),
        .csr_addr_i (csr_addr_i),
        .wr_o       (wr_s)
    );

    for (genvar g = 0; g < ZOL_NLOOPS; g++) begin : g_set
        zol_regset regset_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (wr_s[g]),
            .wdata_i (csr_wdata_i),
            .step_i  (step_s[g]),
            .regs_o  (regs_s[g])
        );
    end

    zol_arbiter arbiter_i (
        .pc_i          (pc_i),
        .pc_valid_i    (pc_valid_i),
        .regs_i        (regs_s),
        .step_o        (step_s),
        .jump_o        (jump_o),
        .jump_target_o (jump_target_o)
    );

    assign loop0_start_o = regs_s[0].start_addr;
    assign loop0_end_o   = regs_s[0].end_addr;
    assign loop0_count_o = regs_s[0].count;
    assign loop1_start_o = regs_s[1].start_addr;
    assign loop1_end_o   = regs_s[1].end_addr;
    assign loop1_count_o = regs_s[1].count;

    AST_JUMP_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jump_o |-> pc_valid_i); // R6

    AST_JUMP_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jump_o |-> (pc_i == loop0_end_o || pc_i == loop1_end_o)); // R4

    AST_TARGET_IS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jump_o |-> (jump_target_o == loop0_start_o || jump_target_o == loop1_start_o)); // R4

    AST_NO_JUMP_SPENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_valid_i && pc_i == loop0_end_o && pc_i != loop1_end_o
         && loop0_count_o <= cnt_t'(1)) |-> !jump_o); // R5

    AST_SHARED_LOOP0_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_valid_i && pc_i == loop0_end_o && loop0_end_o == loop1_end_o
         && loop0_count_o > cnt_t'(1)) |-> (jump_o && jump_target_o == loop0_start_o)); // R7

    AST_SHARED_LOOP1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_valid_i && pc_i == loop0_end_o && loop0_end_o == loop1_end_o
         && loop0_count_o > cnt_t'(1) && !wr_s[1].count_we) |=> $stable(loop1_count_o)); // R7

    AST_SHARED_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_valid_i && pc_i == loop0_end_o && loop0_end_o == loop1_end_o
         && loop0_count_o <= cnt_t'(1) && loop1_count_o > cnt_t'(1))
        |-> (jump_o && jump_target_o == loop1_start_o)); // R8

endmodule

// File: tb/zol_ctrl_tb_top.sv
module zol_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] pc;
        logic        vld;
        logic        jmp;
        logic [31:0] tgt;
        logic [31:0] c0;
        logic [31:0] c1;
    } vec_t;

    // loop 0: 0x100..0x10C count 3, loop 1: 0x200..0x20C count 2
    localparam vec_t VECS [8] = '{
        '{32'h104, 1'b1, 1'b0, 32'h0,   32'd3, 32'd2}, // inside body
        '{32'h10C, 1'b1, 1'b1, 32'h100, 32'd2, 32'd2}, // R4 loop 0 jump
        '{32'h10C, 1'b0, 1'b0, 32'h0,   32'd2, 32'd2}, // R6 strobe low
        '{32'h10C, 1'b1, 1'b1, 32'h100, 32'd1, 32'd2}, // R4 again
        '{32'h10C, 1'b1, 1'b0, 32'h0,   32'd0, 32'd2}, // R5 count 1
        '{32'h10C, 1'b1, 1'b0, 32'h0,   32'd0, 32'd2}, // R5 count 0 holds
        '{32'h20C, 1'b1, 1'b1, 32'h200, 32'd0, 32'd1}, // R4 loop 1 jump
        '{32'h20C, 1'b1, 1'b0, 32'h0,   32'd0, 32'd0}  // R5 loop 1 spent
    };

    logic        clk;
    logic        rst_n;
    logic [31:0] pc;
    logic        pc_valid;
    logic        csr_we;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata;
    logic        jump;
    logic [31:0] target;
    logic [31:0] s0, e0, c0, s1, e1, c1;

    int n_checks = 0;
    int n_errors = 0;
    logic done = 1'b0;

    zol_ctrl dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .pc_i          (pc),
        .pc_valid_i    (pc_valid),
        .csr_we_i      (csr_we),
        .csr_addr_i    (csr_addr),
        .csr_wdata_i   (csr_wdata),
        .jump_o        (jump),
        .jump_target_o (target),
        .loop0_start_o (s0),
        .loop0_end_o   (e0),
        .loop0_count_o (c0),
        .loop1_start_o (s1),
        .loop1_end_o   (e1),
        .loop1_count_o (c1)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(posedge clk);
        #1;
        csr_we = 1'b0;
    endtask

    task automatic pc_step(input logic [31:0] p, input logic v,
                           output logic j, output logic [31:0] t);
        @(negedge clk);
        pc = p; pc_valid = v;
        #1;
        j = jump; t = target;
        @(posedge clk);
        #1;
        pc_valid = 1'b0;
    endtask

    task automatic check_all(input string tag, input logic [31:0] xs0, xe0, xc0,
                             input logic [31:0] xs1, xe1, xc1);
        check({tag, " loop0 start"}, s0, xs0);
        check({tag, " loop0 end"},   e0, xe0);
        check({tag, " loop0 count"}, c0, xc0);
        check({tag, " loop1 start"}, s1, xs1);
        check({tag, " loop1 end"},   e1, xe1);
        check({tag, " loop1 count"}, c1, xc1);
    endtask

    initial begin
        logic        j;
        logic [31:0] t;
        rst_n = 1'b0; pc = '0; pc_valid = 1'b0;
        csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset", 0, 0, 0, 0, 0, 0);
        check("R1 reset jump", {31'b0, jump}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 register map
        csr_wr(12'h7B0, 32'h100);
        csr_wr(12'h7B1, 32'h10C);
        csr_wr(12'h7B2, 32'd3);
        csr_wr(12'h7B4, 32'h200);
        csr_wr(12'h7B5, 32'h20C);
        csr_wr(12'h7B6, 32'd2);
        check_all("R2 write map", 32'h100, 32'h10C, 3, 32'h200, 32'h20C, 2);

        // R3 undecoded addresses and strobe low
        csr_wr(12'h7B3, 32'hDEAD);
        csr_wr(12'h7B7, 32'hBEEF);
        csr_wr(12'h7A0, 32'h1234);
        csr_wr(12'h7B8, 32'h5678);
        @(negedge clk);
        csr_we = 1'b0; csr_addr = 12'h7B2; csr_wdata = 32'h55;
        @(posedge clk);
        #1;
        check_all("R3 ignored writes", 32'h100, 32'h10C, 3, 32'h200, 32'h20C, 2);

        // table: R4 R5 R6 with separate ends
        for (int i = 0; i < 8; i++) begin
            pc_step(VECS[i].pc, VECS[i].vld, j, t);
            check($sformatf("R4 R5 R6 row %0d jump", i), {31'b0, j}, {31'b0, VECS[i].jmp});
            if (VECS[i].jmp) check($sformatf("R4 row %0d target", i), t, VECS[i].tgt);
            check($sformatf("R4 R5 row %0d loop0 count", i), c0, VECS[i].c0);
            check($sformatf("R4 R5 row %0d loop1 count", i), c1, VECS[i].c1);
        end

        // shared end address
        csr_wr(12'h7B0, 32'h2F0);
        csr_wr(12'h7B1, 32'h300);
        csr_wr(12'h7B2, 32'd2);
        csr_wr(12'h7B4, 32'h280);
        csr_wr(12'h7B5, 32'h300);
        csr_wr(12'h7B6, 32'd3);
        pc_step(32'h300, 1'b1, j, t);
        check("R7 jump", {31'b0, j}, 32'd1);
        check("R7 target loop0", t, 32'h2F0);
        check("R7 loop0 count", c0, 32'd1);
        check("R7 loop1 count held", c1, 32'd3);
        pc_step(32'h300, 1'b1, j, t);
        check("R8 jump", {31'b0, j}, 32'd1);
        check("R8 target loop1", t, 32'h280);
        check("R8 loop0 count", c0, 32'd0);
        check("R8 loop1 count", c1, 32'd2);
        pc_step(32'h300, 1'b1, j, t);
        check("R8 loop0 spent jump", {31'b0, j}, 32'd1);
        check("R8 loop0 spent target", t, 32'h280);
        check("R8 loop0 spent loop1 count", c1, 32'd1);
        pc_step(32'h300, 1'b1, j, t);
        check("R5 shared both spent jump", {31'b0, j}, 32'd0);
        check("R5 shared loop1 count", c1, 32'd0);

        // R9 write collides with decrement
        csr_wr(12'h7B0, 32'h3F0);
        csr_wr(12'h7B1, 32'h400);
        csr_wr(12'h7B2, 32'd5);
        @(negedge clk);
        pc = 32'h400; pc_valid = 1'b1;
        csr_we = 1'b1; csr_addr = 12'h7B2; csr_wdata = 32'd9;
        #1;
        j = jump; t = target;
        @(posedge clk);
        #1;
        pc_valid = 1'b0; csr_we = 1'b0;
        check("R9 jump on old count", {31'b0, j}, 32'd1);
        check("R9 target", t, 32'h3F0);
        check("R9 written count wins", c0, 32'd9);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule